// File: doc/BRIEF.md
# Asynchronous SRAM strobe sequencer

This block is a synchronous controller placed between a host port with a simple request and acknowledge handshake and an external asynchronous static RAM. The memory side has a 21-bit address, an 8-bit data bus that both sides can drive, an active-low primary select, an active-high secondary select, an active-low write strobe and an active-low output enable. Each host request becomes one ordered strobe sequence. Every timing window of that sequence is a whole number of system clock cycles, derived at elaboration from nanosecond minimums and the clock period. Read data is captured at the end of the access window and handed back with a one-cycle valid pulse.

The data bus is split into an output value, an output-enable and an input value, so the pad ring can build the tri-state driver. The controller drives the bus only while the write strobe is low. It keeps the output enable high for the whole of every write. Between requests the memory sits in standby with both selects inactive. Only one request is in flight at a time.

The sequencer has seven states. ST_IDLE goes to ST_WR_SETUP on a write request and to ST_RD_SETUP on a read request. The write path runs ST_WR_SETUP to ST_WR_PULSE to ST_WR_RECOV to ST_IDLE. The read path runs ST_RD_SETUP to ST_RD_ACCESS to ST_RD_TURN to ST_IDLE. Each state except ST_IDLE leaves when its phase timer expires, and ST_RD_SETUP always lasts exactly one cycle.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, and in every idle cycle, the outputs show standby: mem_sel_n_o=1, mem_sel_hi_o=0, mem_wr_n_o=1, mem_rd_en_n_o=1, mem_data_oe_o=0.
- R2: ack_o is high only in the idle state while req_i is high, and the request is accepted at that clock edge. While a cycle is in progress ack_o stays low, and the host inputs have no effect: the address presented to the memory keeps the accepted value.
- R3: The write sequence runs in three phases. First, C_AS cycles selected (sel_n=0, sel_hi=1) with wr_n=1, rd_en_n=1 and the bus released. Then C_WP cycles with wr_n=0 and the bus driven with the accepted write data. Then C_WR cycles selected with wr_n=1 and the bus released. After that comes standby.
- R4: The read sequence runs in three phases. First, one cycle selected with rd_en_n=1. Then C_AA cycles selected with rd_en_n=0, wr_n=1 and the bus released. Then C_TURN cycles in standby. After that comes idle.
- R5: Read data is sampled from mem_data_i on the last cycle of the access window. rd_valid_o is high for exactly one cycle, the first turnaround cycle, with rd_data_o holding the sampled byte.
- R6: cyc(x) = max(1, ceil(x / CLK_PERIOD_NS)). C_AS = cyc(T_ADDR_SETUP_NS). C_WP = cyc(max(T_WRITE_PULSE_NS, T_DATA_SETUP_NS, T_ADDR_TO_WEND_NS)). C_WR = max(cyc(T_WRITE_RECOV_NS), cyc(T_WRITE_CYCLE_NS) - C_AS - C_WP). C_AA = cyc(T_ACCESS_NS). C_TURN = cyc(T_TURN_NS).
- R7: The output enable stays high throughout every write cycle. The data bus is driven only in cycles where the write strobe is low.
- R8: The controller never drives the bus while the output enable is low. The bus is released at least one cycle before the output enable falls.
- R9: The memory address changes only at acceptance, while the memory is deselected. It is stable for as long as the memory stays selected.
- R10: The write strobe is low only while the memory is selected (sel_n=0 and sel_hi=1).
- R11: rd_data_o keeps the last read byte until the next read completes, and it is not changed by writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Host request, held until ack_o |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Host address |
| req_wdata_i | input | DATA_W | Host write data |
| ack_o | output | 1 | Request accepted at this edge |
| rd_valid_o | output | 1 | One-cycle pulse, read data ready |
| rd_data_o | output | DATA_W | Last read byte |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_sel_n_o | output | 1 | Primary select, active low |
| mem_sel_hi_o | output | 1 | Secondary select, active high |
| mem_wr_n_o | output | 1 | Write strobe, active low |
| mem_rd_en_n_o | output | 1 | Memory output enable, active low |
| mem_data_o | output | DATA_W | Value for the data bus driver |
| mem_data_oe_o | output | 1 | Enable for the data bus driver |
| mem_data_i | input | DATA_W | Value seen on the data bus |

## Verification
The hardest case to provoke from the ports is a read sampled one cycle too early or too late. A memory that returns data instantly would hide either fault. The bench memory model therefore returns the inverted stored byte until the output enable has been low for C_AA cycles, so only a sample in the last access cycle yields the stored value. Every transaction also keeps req_i high with inverted, conflicting fields while busy, which shows that a second request is neither acknowledged nor allowed to disturb the address.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOV,
        ST_RD_SETUP,
        ST_RD_ACCESS,
        ST_RD_TURN
    } seq_state_e;

    // whole cycles covering a nanosecond minimum, never below one
    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max_of2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             last_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = (cnt_q == '0);

    // R6: an expired window stays expired until the next phase reloads it
    p_last_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !load_i) |=> last_o);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_seq_pkg::*;
#(
    parameter int C_AS   = 1,
    parameter int C_WP   = 1,
    parameter int C_WR   = 1,
    parameter int C_AA   = 1,
    parameter int C_TURN = 1,
    parameter int CNT_W  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             req_we_i,
    input  logic             phase_last_i,
    output logic             accept_o,
    output logic             load_o,
    output logic [CNT_W-1:0] load_val_o,
    output logic             drive_nxt_o,
    output logic             capture_o,
    output logic             sel_n_o,
    output logic             sel_hi_o,
    output logic             wr_n_o,
    output logic             rd_en_n_o
);

    localparam logic [CNT_W-1:0] LV_AS   = CNT_W'(C_AS - 1);
    localparam logic [CNT_W-1:0] LV_WP   = CNT_W'(C_WP - 1);
    localparam logic [CNT_W-1:0] LV_WR   = CNT_W'(C_WR - 1);
    localparam logic [CNT_W-1:0] LV_AA   = CNT_W'(C_AA - 1);
    localparam logic [CNT_W-1:0] LV_TURN = CNT_W'(C_TURN - 1);

    seq_state_e state_q;
    seq_state_e state_nxt;
    logic       sel_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // next state and phase timer reload
    always_comb begin
        state_nxt  = state_q;
        load_o     = 1'b0;
        load_val_o = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    load_o = 1'b1;
                    if (req_we_i) begin
                        state_nxt  = ST_WR_SETUP;
                        load_val_o = LV_AS;
                    end else begin
                        state_nxt  = ST_RD_SETUP;
                        load_val_o = '0;
                    end
                end
            end
            ST_WR_SETUP: begin
                if (phase_last_i) begin
                    state_nxt  = ST_WR_PULSE;
                    load_o     = 1'b1;
                    load_val_o = LV_WP;
                end
            end
            ST_WR_PULSE: begin
                if (phase_last_i) begin
                    state_nxt  = ST_WR_RECOV;
                    load_o     = 1'b1;
                    load_val_o = LV_WR;
                end
            end
            ST_WR_RECOV: begin
                if (phase_last_i) begin
                    state_nxt = ST_IDLE;
                end
            end
            ST_RD_SETUP: begin
                state_nxt  = ST_RD_ACCESS;
                load_o     = 1'b1;
                load_val_o = LV_AA;
            end
            ST_RD_ACCESS: begin
                if (phase_last_i) begin
                    state_nxt  = ST_RD_TURN;
                    load_o     = 1'b1;
                    load_val_o = LV_TURN;
                end
            end
            ST_RD_TURN: begin
                if (phase_last_i) begin
                    state_nxt = ST_IDLE;
                end
            end
            default: begin
                state_nxt = ST_IDLE;
            end
        endcase
    end

    assign accept_o    = (state_q == ST_IDLE) && req_i;
    assign capture_o   = (state_q == ST_RD_ACCESS) && phase_last_i;
    assign drive_nxt_o = (state_nxt == ST_WR_PULSE);
    assign sel_nxt     = state_nxt inside {ST_WR_SETUP, ST_WR_PULSE, ST_WR_RECOV,
                                           ST_RD_SETUP, ST_RD_ACCESS};

    // strobes registered from the next state, so each pin changes only at an edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_n_o   <= 1'b1;
            sel_hi_o  <= 1'b0;
            wr_n_o    <= 1'b1;
            rd_en_n_o <= 1'b1;
        end else begin
            sel_n_o   <= !sel_nxt;
            sel_hi_o  <= sel_nxt;
            wr_n_o    <= (state_nxt != ST_WR_PULSE);
            rd_en_n_o <= (state_nxt != ST_RD_ACCESS);
        end
    end

    // R7: output enable never low together with the write strobe
    p_rd_en_off_in_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_o |-> rd_en_n_o);

    // R10: write strobe only inside a selected window
    p_wr_selected_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_o |-> (!sel_n_o && sel_hi_o));

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic              drive_nxt_i,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_data_o,
    output logic              mem_data_oe_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr_o <= '0;
            mem_data_o <= '0;
        end else if (accept_i) begin
            mem_addr_o <= req_addr_i;
            mem_data_o <= req_wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_data_oe_o <= 1'b0;
        end else begin
            mem_data_oe_o <= drive_nxt_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o  <= '0;
            rd_valid_o <= 1'b0;
        end else begin
            rd_valid_o <= capture_i;
            if (capture_i) begin
                rd_data_o <= mem_data_i;
            end
        end
    end

    // R5: the valid flag is a single-cycle pulse
    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |=> !rd_valid_o);

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W             = 21,
    parameter int DATA_W             = 8,
    parameter int CLK_PERIOD_NS      = 20,
    parameter int T_ADDR_SETUP_NS    = 0,
    parameter int T_WRITE_PULSE_NS   = 8,
    parameter int T_DATA_SETUP_NS    = 6,
    parameter int T_ADDR_TO_WEND_NS  = 8,
    parameter int T_WRITE_RECOV_NS   = 0,
    parameter int T_WRITE_CYCLE_NS   = 10,
    parameter int T_ACCESS_NS        = 10,
    parameter int T_TURN_NS          = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              req_we_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              ack_o,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_sel_n_o,
    output logic              mem_sel_hi_o,
    output logic              mem_wr_n_o,
    output logic              mem_rd_en_n_o,
    output logic [DATA_W-1:0] mem_data_o,
    output logic              mem_data_oe_o,
    input  logic [DATA_W-1:0] mem_data_i
);

    localparam int C_AS     = ns_to_cyc(T_ADDR_SETUP_NS, CLK_PERIOD_NS);
    localparam int C_WP     = ns_to_cyc(max_of2(T_WRITE_PULSE_NS,
                                        max_of2(T_DATA_SETUP_NS, T_ADDR_TO_WEND_NS)),
                                        CLK_PERIOD_NS);
    localparam int C_WC     = ns_to_cyc(T_WRITE_CYCLE_NS, CLK_PERIOD_NS);
    localparam int C_WR_MIN = ns_to_cyc(T_WRITE_RECOV_NS, CLK_PERIOD_NS);
    localparam int C_WR     = max_of2(C_WR_MIN, C_WC - C_AS - C_WP);
    localparam int C_AA     = ns_to_cyc(T_ACCESS_NS, CLK_PERIOD_NS);
    localparam int C_TURN   = ns_to_cyc(T_TURN_NS, CLK_PERIOD_NS);
    localparam int C_MAX    = max_of2(max_of2(C_AS, C_WP),
                                      max_of2(max_of2(C_WR, C_AA), C_TURN));
    localparam int CNT_W    = $clog2(C_MAX + 1);

    logic             accept;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             phase_last;
    logic             drive_nxt;
    logic             capture;

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (load_val),
        .last_o     (phase_last)
    );

    sram_seq_fsm #(
        .C_AS   (C_AS),
        .C_WP   (C_WP),
        .C_WR   (C_WR),
        .C_AA   (C_AA),
        .C_TURN (C_TURN),
        .CNT_W  (CNT_W)
    ) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .req_we_i     (req_we_i),
        .phase_last_i (phase_last),
        .accept_o     (accept),
        .load_o       (load),
        .load_val_o   (load_val),
        .drive_nxt_o  (drive_nxt),
        .capture_o    (capture),
        .sel_n_o      (mem_sel_n_o),
        .sel_hi_o     (mem_sel_hi_o),
        .wr_n_o       (mem_wr_n_o),
        .rd_en_n_o    (mem_rd_en_n_o)
    );

    sram_data_path #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) path_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .accept_i      (accept),
        .req_addr_i    (req_addr_i),
        .req_wdata_i   (req_wdata_i),
        .drive_nxt_i   (drive_nxt),
        .capture_i     (capture),
        .mem_data_i    (mem_data_i),
        .mem_addr_o    (mem_addr_o),
        .mem_data_o    (mem_data_o),
        .mem_data_oe_o (mem_data_oe_o),
        .rd_data_o     (rd_data_o),
        .rd_valid_o    (rd_valid_o)
    );

    assign ack_o = accept;

    // R7: the bus driver is on only during the write strobe
    p_drive_in_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_data_oe_o |-> !mem_wr_n_o);

    // R8: no overlap of both drivers
    p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_en_n_o |-> !mem_data_oe_o);

    // R8: the bus was already released in the cycle before the output enable fell
    p_release_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rd_en_n_o) |-> !$past(mem_data_oe_o));

    // R9: the address holds while the memory stays selected
    p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_n_o && $past(!mem_sel_n_o)) |-> $stable(mem_addr_o));

endmodule

// File: tb/sram_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_seq_ctrl_tb_top;

    localparam int AW     = 6;
    localparam int DW     = 8;
    localparam int PER_NS = 3;
    localparam int AS_NS  = 4;
    localparam int DEPTH  = 1 << AW;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + PER_NS - 1) / PER_NS;
        return (c < 1) ? 1 : c;
    endfunction

    // R6 arithmetic for the bench configuration
    localparam int EC_AS   = cyc(AS_NS);
    localparam int EC_WP   = cyc(8);
    localparam int EC_WC   = cyc(10);
    localparam int EC_WR   = (EC_WC - EC_AS - EC_WP > cyc(0)) ? (EC_WC - EC_AS - EC_WP) : cyc(0);
    localparam int EC_AA   = cyc(10);
    localparam int EC_TURN = cyc(4);

    // strobe vector {sel_n, sel_hi, wr_n, rd_en_n, data_oe}
    localparam logic [4:0] V_STBY  = 5'b10110;
    localparam logic [4:0] V_SEL   = 5'b01110;
    localparam logic [4:0] V_PULSE = 5'b01011;
    localparam logic [4:0] V_RACC  = 5'b01100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          ack;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] mem_addr;
    logic          sel_n, sel_hi, wr_n, rd_en_n, data_oe;
    logic [DW-1:0] data_out;
    logic [DW-1:0] data_in;

    int checks = 0;
    int errors = 0;
    int clash  = 0;

    always #10 clk = ~clk;

    sram_seq_ctrl #(
        .ADDR_W          (AW),
        .DATA_W          (DW),
        .CLK_PERIOD_NS   (PER_NS),
        .T_ADDR_SETUP_NS (AS_NS)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (req),
        .req_we_i      (req_we),
        .req_addr_i    (req_addr),
        .req_wdata_i   (req_wdata),
        .ack_o         (ack),
        .rd_valid_o    (rd_valid),
        .rd_data_o     (rd_data),
        .mem_addr_o    (mem_addr),
        .mem_sel_n_o   (sel_n),
        .mem_sel_hi_o  (sel_hi),
        .mem_wr_n_o    (wr_n),
        .mem_rd_en_n_o (rd_en_n),
        .mem_data_o    (data_out),
        .mem_data_oe_o (data_oe),
        .mem_data_i    (data_in)
    );

    // memory model: data becomes valid only after EC_AA cycles of output enable
    logic [DW-1:0] mem [DEPTH];
    int            oe_cnt = 0;
    logic          selected;
    assign selected = !sel_n && sel_hi;

    always @(posedge clk) begin
        if (selected && !wr_n && data_oe) mem[mem_addr] <= data_out;
        if (data_oe && !rd_en_n) clash <= clash + 1;
        oe_cnt <= (selected && !rd_en_n && wr_n) ? oe_cnt + 1 : 0;
    end

    always_comb begin
        if (selected && !rd_en_n && wr_n && oe_cnt >= EC_AA - 1) data_in = mem[mem_addr];
        else data_in = ~mem[mem_addr];
    end

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return DW'((a * 37 + 5 + salt * 91) & 255);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [4:0] strb();
        return {sel_n, sel_hi, wr_n, rd_en_n, data_oe};
    endfunction

    // starts and ends just after a falling edge, controller idle
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        req = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
        #1 chk("R2 ack in idle", 32'(ack), 32'd1);
        @(negedge clk);
        req_we = 1'b0; req_addr = ~a; req_wdata = ~d;   // ignored while busy
        for (int i = 0; i < EC_AS; i++) begin
            chk("R3 write setup strobes", 32'(strb()), 32'(V_SEL));
            chk("R2 no ack while busy", 32'(ack), 32'd0);
            chk("R9 address held", 32'(mem_addr), 32'(a));
            @(negedge clk);
        end
        for (int i = 0; i < EC_WP; i++) begin
            chk("R7 write pulse strobes", 32'(strb()), 32'(V_PULSE));
            chk("R3 write data driven", 32'(data_out), 32'(d));
            chk("R9 address held", 32'(mem_addr), 32'(a));
            @(negedge clk);
        end
        for (int i = 0; i < EC_WR; i++) begin
            chk("R3 write recovery strobes", 32'(strb()), 32'(V_SEL));
            chk("R2 no ack while busy", 32'(ack), 32'd0);
            if (i == EC_WR - 1) req = 1'b0;
            @(negedge clk);
        end
        chk("R1 standby after write", 32'(strb()), 32'(V_STBY));
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp_d);
        req = 1'b1; req_we = 1'b0; req_addr = a;
        #1 chk("R2 ack in idle", 32'(ack), 32'd1);
        @(negedge clk);
        req_we = 1'b1; req_addr = ~a;                  // ignored while busy
        chk("R4 read setup strobes", 32'(strb()), 32'(V_SEL));
        @(negedge clk);
        for (int i = 0; i < EC_AA; i++) begin
            chk("R4 read access strobes", 32'(strb()), 32'(V_RACC));
            chk("R9 address held", 32'(mem_addr), 32'(a));
            chk("R5 no early valid", 32'(rd_valid), 32'd0);
            @(negedge clk);
        end
        for (int i = 0; i < EC_TURN; i++) begin
            chk("R4 turnaround standby", 32'(strb()), 32'(V_STBY));
            chk("R2 no ack in turnaround", 32'(ack), 32'd0);
            chk("R5 valid pulse position", 32'(rd_valid), (i == 0) ? 32'd1 : 32'd0);
            if (i == 0) chk("R5 read data", 32'(rd_data), 32'(exp_d));
            if (i == EC_TURN - 1) req = 1'b0;
            @(negedge clk);
        end
        chk("R1 standby after read", 32'(strb()), 32'(V_STBY));
        chk("R5 valid is one cycle", 32'(rd_valid), 32'd0);
        chk("R11 data held", 32'(rd_data), 32'(exp_d));
    endtask

    task automatic run_all();
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset strobes", 32'(strb()), 32'(V_STBY));
        chk("R5 reset valid", 32'(rd_valid), 32'd0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R1 idle strobes", 32'(strb()), 32'(V_STBY));
            chk("R2 no ack without request", 32'(ack), 32'd0);
        end
        // R6 cross-check of the derived windows against the arithmetic
        chk("R6 bench window sanity", 32'(EC_AS + EC_WP + EC_WR), 32'd6);
        for (int a = 0; a < DEPTH; a++) do_write(AW'(a), pat(a, 0));
        for (int a = 0; a < DEPTH; a++) do_read(AW'(a), pat(a, 0));
        // overwrite then read back, back to back, including the end addresses
        for (int a = 0; a < DEPTH; a += 7) begin
            do_write(AW'(a), pat(a, 1));
            do_read(AW'(a), pat(a, 1));
        end
        do_write(AW'(DEPTH - 1), 8'h5A);
        do_write(AW'(0), 8'hC3);
        do_read(AW'(DEPTH - 1), 8'h5A);
        // R11: a write leaves the previous read byte in place
        do_write(AW'(3), 8'h99);
        chk("R11 data unchanged by write", 32'(rd_data), 32'h5A);
        do_read(AW'(0), 8'hC3);
        do_read(AW'(3), 8'h99);
        chk("R8 no bus contention seen", 32'(clash), 32'd0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog R1 actual=hung expected=done");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule